// File: doc/BRIEF.md
# ADC Sample Serializer

This block takes one 14-bit conversion result per sample period and sends it out serially, one bit slot per bit clock, together with a word marker and a copy of the bit clock. It runs entirely in the bit-clock domain. The edge of the sample clock reaches it as a one-cycle strobe, `sample_valid`, that is synchronous to that domain.

Each strobe pushes the new sample into a fixed six-sample delay line. At the same edge it starts a new serial word that carries the sample pushed six strobes earlier. The word uses one of two lane layouts. With one lane, every bit goes out on lane A in descending order. With two lanes, the odd-indexed bits go out on lane A and the even-indexed bits on lane B, side by side. The frame length can be the native 14 bits, 16 bits (zero-padded) or 12 bits (the two lowest bits dropped).

Lane mode and frame length are captured only when a word starts. A change on those inputs therefore never splits a word. A strobe that comes before the running word has shown its last slot raises a one-cycle overrun pulse and restarts serialization with the new word.

Top module: `adcser_top`

## Requirements
- R1: With `lane_mode`=0 (one lane) and `width_sel`=01 or 11 (14-bit frame), lane A shows D13, D12, ..., D0, one bit per bit-clock cycle. Lane B and `lane_b_en` stay 0.
- R2: With `lane_mode`=1 (two lanes), slot k of lane A carries D(13-2k) and slot k of lane B carries D(12-2k). `lane_b_en` is 1 while such a word runs. A 14-bit frame then lasts 7 slots.
- R3: With `width_sel`=00 (16-bit frame), one lane sends D13..D0 followed by two 0 slots. Two lanes send their 7 data bits followed by one 0 slot, for 8 slots in all.
- R4: With `width_sel`=10 (12-bit frame), D1 and D0 are not sent. One lane sends D13..D2 in 12 slots. Two lanes send D13..D3 (odd) on A and D12..D2 (even) on B in 6 slots.
- R5: The word started by the n-th strobe since reset (counting from 0) carries the sample given with strobe n-6. The words of strobes 0 to 5 are all zeros.
- R6: Slot 0 is visible right after the clock edge that samples the strobe, and one slot follows per cycle. After the last slot, with no new strobe, lanes A and B and the frame marker are 0.
- R7: `frame` is 1 during the first ceil(L/2) slots of a word of L slots and 0 during the rest, and 0 when idle. Its rising edge therefore marks slot 0.
- R8: `lane_mode` and `width_sel` are used only at a strobe edge. Changing them during a word does not change that word.
- R9: A strobe while the running word has not yet reached its last slot makes `overrun` 1 for exactly the cycle after that edge. The new word starts at slot 0.
- R10: `bit_clk_out` is a copy of `clk`.
- R11: While reset is applied, and until the first strobe, all outputs other than `bit_clk_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all logic runs on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sample_valid | input | 1 | One-cycle strobe marking a sample-clock edge |
| sample | input | 14 | Conversion result D13..D0 |
| lane_mode | input | 1 | 0 = one lane, 1 = two lanes |
| width_sel | input | 2 | 00 = 16-bit, 01 = 14-bit, 10 = 12-bit, 11 = 14-bit frame |
| lane_a | output | 1 | Serial data, lane A |
| lane_b | output | 1 | Serial data, lane B |
| lane_b_en | output | 1 | Lane B carries data in the running word |
| frame | output | 1 | Word marker, high for the first half of the word |
| bit_clk_out | output | 1 | Forwarded bit clock |
| overrun | output | 1 | One-cycle pulse when a word is cut short by a new strobe |

## Verification
Slot k of a word is due on the lanes and on the frame marker k+1 cycles after the strobe's edge is presented. The overrun pulse is due one cycle after the strobe that causes it, on the same cycle as slot 0. The sample carried is the one given six strobes earlier. The bench drives inputs and samples outputs on falling edges. It holds a history of every sample it has sent, so each expected slot is computed from the sample six strobes back. It scrambles the mode inputs and the sample bus during every word, so that any dependency on those inputs outside a strobe shows up as a mismatch.

// File: rtl/adcser_pkg.sv
package adcser_pkg;
  typedef enum logic [1:0] {
    WID_WIDE   = 2'b00,
    WID_NATIVE = 2'b01,
    WID_NARROW = 2'b10,
    WID_ALT    = 2'b11
  } width_e;

  typedef enum logic {
    LANES_ONE = 1'b0,
    LANES_TWO = 1'b1
  } lanes_e;
endpackage

// File: rtl/adcser_delay.sv
module adcser_delay #(
  parameter int DW    = 14,
  parameter int DEPTH = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  logic [DW-1:0] dl_q [DEPTH];
  logic [DW-1:0] dl_n [DEPTH];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) dl_n[i] = dl_q[i];
    if (shift_en) begin
      dl_n[0] = din;
      for (int i = 1; i < DEPTH; i++) dl_n[i] = dl_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) dl_q[i] <= '0;
    end else if (shift_en) begin
      for (int i = 0; i < DEPTH; i++) dl_q[i] <= dl_n[i];
    end
  end

  assign dout = dl_q[DEPTH-1];

  // R5: a strobe pushes the presented sample into the first stage
  a_r5_delay_push: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (dl_q[0] == $past(din)));
endmodule

// File: rtl/adcser_mapper.sv
module adcser_mapper
  import adcser_pkg::*;
#(
  parameter int SW   = 14,
  parameter int MAXW = SW + 2,
  parameter int CLW  = $clog2(MAXW + 1)
) (
  input  logic [SW-1:0]   din,
  input  logic            two_lane,
  input  logic [1:0]      width_sel,
  output logic [MAXW-1:0] a_word,
  output logic [MAXW-1:0] b_word,
  output logic [CLW-1:0]  slots
);
  localparam int HALF = SW / 2;

  logic [CLW-1:0] cnt_one;
  logic [CLW-1:0] cnt_two;
  logic [CLW-1:0] frame_len;

  always_comb begin
    cnt_one   = (width_e'(width_sel) == WID_NARROW) ? CLW'(SW - 2) : CLW'(SW);
    cnt_two   = cnt_one >> 1;
    frame_len = (width_e'(width_sel) == WID_WIDE) ? CLW'(SW + 2) : cnt_one;
    slots     = two_lane ? (frame_len >> 1) : frame_len;
  end

  for (genvar k = 0; k < MAXW; k++) begin : g_slot
    logic bit_one;
    logic bit_two_a;
    logic bit_two_b;
    if (k < SW) begin : g_one
      assign bit_one = (CLW'(k) < cnt_one) ? din[SW-1-k] : 1'b0;
    end else begin : g_one_pad
      assign bit_one = 1'b0;
    end
    if (k < HALF) begin : g_two
      assign bit_two_a = (CLW'(k) < cnt_two) ? din[SW-1-2*k] : 1'b0;
      assign bit_two_b = (CLW'(k) < cnt_two) ? din[SW-2-2*k] : 1'b0;
    end else begin : g_two_pad
      assign bit_two_a = 1'b0;
      assign bit_two_b = 1'b0;
    end
    assign a_word[k] = two_lane ? bit_two_a : bit_one;
    assign b_word[k] = two_lane ? bit_two_b : 1'b0;
  end
endmodule

// File: rtl/adcser_shifter.sv
module adcser_shifter #(
  parameter int MAXW = 16,
  parameter int CLW  = $clog2(MAXW + 1),
  parameter int CW   = $clog2(MAXW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [MAXW-1:0] a_word,
  input  logic [MAXW-1:0] b_word,
  input  logic [CLW-1:0]  slots,
  input  logic            two_lane,
  output logic            lane_a,
  output logic            lane_b,
  output logic            lane_b_en,
  output logic            frame,
  output logic            overrun
);
  logic [MAXW-1:0] a_q, a_n;
  logic [MAXW-1:0] b_q, b_n;
  logic [CLW-1:0]  len_q, len_n;
  logic [CW-1:0]   cnt_q, cnt_n;
  logic            two_q, two_n;
  logic            act_q, act_n;
  logic            err_q, err_n;
  logic            last;
  logic [CLW-1:0]  half;

  assign last = act_q && ({1'b0, cnt_q} == (len_q - 1'b1));
  assign half = (len_q + 1'b1) >> 1;

  always_comb begin
    a_n   = a_q;
    b_n   = b_q;
    len_n = len_q;
    two_n = two_q;
    cnt_n = cnt_q;
    act_n = act_q;
    err_n = 1'b0;
    if (load) begin
      a_n   = a_word;
      b_n   = b_word;
      len_n = slots;
      two_n = two_lane;
      cnt_n = '0;
      act_n = 1'b1;
      err_n = act_q && !last;
    end else if (act_q) begin
      if (last) act_n = 1'b0;
      else      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= '0;
      b_q   <= '0;
      len_q <= CLW'(1);
      two_q <= 1'b0;
      cnt_q <= '0;
      act_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      a_q   <= a_n;
      b_q   <= b_n;
      len_q <= len_n;
      two_q <= two_n;
      cnt_q <= cnt_n;
      act_q <= act_n;
      err_q <= err_n;
    end
  end

  assign lane_a    = act_q & a_q[cnt_q];
  assign lane_b    = act_q & b_q[cnt_q];
  assign lane_b_en = act_q & two_q;
  assign frame     = act_q && ({1'b0, cnt_q} < half);
  assign overrun   = err_q;

  // R6: the slot counter never runs past the word length
  a_r6_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> ({1'b0, cnt_q} < len_q));
  // R8: the captured configuration holds for the whole word
  a_r8_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !load) |=> ($stable(two_q) && $stable(len_q)));
  // R9: a strobe before the last slot raises the overrun pulse
  a_r9_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (load && act_q && !last) |=> overrun);
  // R1: lane B is silent whenever lane B is not enabled
  a_r1_laneb_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lane_b_en |-> !lane_b);
  // R7: the frame marker rises only on slot 0
  a_r7_frame_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame) |-> (cnt_q == '0));
endmodule

// File: rtl/adcser_top.sv
module adcser_top
  import adcser_pkg::*;
#(
  parameter int SW        = 14,
  parameter int LAT       = 6,
  parameter int SYNC_FLOPS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample_valid,
  input  logic [SW-1:0] sample,
  input  logic          lane_mode,
  input  logic [1:0]    width_sel,
  output logic          lane_a,
  output logic          lane_b,
  output logic          lane_b_en,
  output logic          frame,
  output logic          bit_clk_out,
  output logic          overrun
);
  localparam int MAXW = SW + 2;
  localparam int CLW  = $clog2(MAXW + 1);
  localparam int CW   = $clog2(MAXW);

  logic [SYNC_FLOPS-1:0] rs_q;
  logic                  rst_i;
  logic [SW-1:0]         old_sample;
  logic [MAXW-1:0]       a_word, b_word;
  logic [CLW-1:0]        slots;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[SYNC_FLOPS-2:0], 1'b1};
  end
  assign rst_i = rs_q[SYNC_FLOPS-1];

  adcser_delay #(.DW(SW), .DEPTH(LAT)) u_delay (
    .clk      (clk),
    .rst_n    (rst_i),
    .shift_en (sample_valid),
    .din      (sample),
    .dout     (old_sample)
  );

  adcser_mapper #(.SW(SW), .MAXW(MAXW), .CLW(CLW)) u_mapper (
    .din       (old_sample),
    .two_lane  (lanes_e'(lane_mode) == LANES_TWO),
    .width_sel (width_sel),
    .a_word    (a_word),
    .b_word    (b_word),
    .slots     (slots)
  );

  adcser_shifter #(.MAXW(MAXW), .CLW(CLW), .CW(CW)) u_shifter (
    .clk       (clk),
    .rst_n     (rst_i),
    .load      (sample_valid),
    .a_word    (a_word),
    .b_word    (b_word),
    .slots     (slots),
    .two_lane  (lane_mode),
    .lane_a    (lane_a),
    .lane_b    (lane_b),
    .lane_b_en (lane_b_en),
    .frame     (frame),
    .overrun   (overrun)
  );

  assign bit_clk_out = clk;
endmodule

// File: tb/adcser_top_bench.sv
module adcser_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sample_valid = 1'b0;
  logic [13:0] sample = '0;
  logic        lane_mode = 1'b0;
  logic [1:0]  width_sel = 2'b01;
  logic        lane_a, lane_b, lane_b_en, frame, bit_clk_out, overrun;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [13:0] hist [1024];
  int nsent = 0;
  bit pend_err = 0;

  always #5 clk = ~clk;

  adcser_top u_adcser_top (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .sample(sample),
    .lane_mode(lane_mode), .width_sel(width_sel), .lane_a(lane_a),
    .lane_b(lane_b), .lane_b_en(lane_b_en), .frame(frame),
    .bit_clk_out(bit_clk_out), .overrun(overrun)
  );

  function automatic int len_of(bit two, logic [1:0] w);
    int l;
    l = (w == 2'b00) ? 16 : (w == 2'b10) ? 12 : 14;
    return two ? l / 2 : l;
  endfunction

  function automatic bit exp_bit(bit on_b, logic [13:0] s, bit two, logic [1:0] w, int k);
    int nd;
    nd = (w == 2'b10) ? 12 : 14;
    if (!two) begin
      if (on_b || k >= nd) return 1'b0;
      return s[13-k];
    end
    if (k >= nd / 2) return 1'b0;
    return on_b ? s[12-2*k] : s[13-2*k];
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // called on a falling edge; observes obs slots of the word started by this strobe
  task automatic send(logic [13:0] s, bit two, logic [1:0] w, int obs);
    logic [13:0] es;
    int L;
    string tag;
    bit err_now;
    es = (nsent >= 6) ? hist[nsent-6] : 14'd0;
    hist[nsent] = s;
    nsent++;
    L = len_of(two, w);
    tag = (w == 2'b00) ? "R3" : (w == 2'b10) ? "R4" : (two ? "R2" : "R1");
    err_now = pend_err;
    sample = s; lane_mode = two; width_sel = w; sample_valid = 1'b1;
    for (int k = 0; k < obs; k++) begin
      @(negedge clk);
      if (k == 0) sample_valid = 1'b0;
      // R8: scramble configuration and sample bus mid-word
      lane_mode = 1'($urandom);
      width_sel = 2'($urandom);
      sample = 14'($urandom);
      check(tag, "lane A slot (R5 R6)", lane_a, exp_bit(1'b0, es, two, w, k));
      check(tag, "lane B slot (R5 R6)", lane_b, exp_bit(1'b1, es, two, w, k));
      check(two ? "R2" : "R1", "lane B enable", lane_b_en, two);
      check("R7", "frame", frame, (k < (L + 1) / 2) ? 1 : 0);
      check("R9", "overrun", overrun, (k == 0) ? err_now : 1'b0);
    end
    pend_err = (obs < L);
  endtask

  task automatic idle_check(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check("R6", "idle lane A", lane_a, 0);
      check("R6", "idle lane B", lane_b, 0);
      check("R7", "idle frame", frame, 0);
    end
    pend_err = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0A1C));
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11", "lane A in reset", lane_a, 0);
    check("R11", "lane B enable in reset", lane_b_en, 0);
    check("R11", "frame in reset", frame, 0);
    check("R11", "overrun in reset", overrun, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R11", "lane A after reset", lane_a, 0);
    check("R11", "frame after reset", frame, 0);
    // R10: forwarded clock
    check("R10", "bit clock low", bit_clk_out, 0);
    @(posedge clk); #1;
    check("R10", "bit clock high", bit_clk_out, 1);
    @(negedge clk);

    // R5: first six words carry zeros
    send(14'h2AAA, 1'b0, 2'b01, 14);
    send(14'h1555, 1'b1, 2'b01, 7);
    send(14'h3FFF, 1'b0, 2'b00, 16);
    send(14'h0001, 1'b1, 2'b00, 8);
    send(14'h2000, 1'b0, 2'b10, 12);
    send(14'h1234, 1'b1, 2'b10, 6);
    // directed: each mode and width with known patterns (R1..R4)
    send(14'h0F0F, 1'b0, 2'b01, 14);
    send(14'h3C3C, 1'b1, 2'b01, 7);
    send(14'h0000, 1'b0, 2'b00, 16);
    send(14'h2AAA, 1'b1, 2'b00, 8);
    send(14'h3FFF, 1'b0, 2'b10, 12);
    send(14'h3FFF, 1'b1, 2'b10, 6);
    send(14'h1555, 1'b0, 2'b11, 14);
    idle_check(5);
    // R9: overrun by an early strobe, then restart
    @(negedge clk);
    send(14'h0AB3, 1'b0, 2'b00, 2);
    send(14'h355C, 1'b1, 2'b01, 3);
    send(14'h1111, 1'b0, 2'b01, 14);
    idle_check(3);
    @(negedge clk);
    // random words
    for (int i = 0; i < 250; i++) begin
      bit two;
      logic [1:0] w;
      two = 1'($urandom);
      w = 2'($urandom);
      send(14'($urandom), two, w, len_of(two, w));
      if ($urandom_range(0, 9) == 0) idle_check($urandom_range(1, 4));
    end
    idle_check(4);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule